// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the floating-point status and control word that sits beside an arithmetic datapath. After each finished operation the datapath pulses a completion strobe together with the five raw exception indications it saw (invalid, divide-by-zero, overflow, underflow, inexact). The controller rebuilds the per-operation cause field from them and folds those causes into a set of sticky flags. When a cause meets a set enable bit, it raises a one-cycle trap request that carries a fixed exception code for the trap sequencer.

The same word drives two static controls back into the datapath. One selects truncation or round-to-nearest-even. The other requests that denormal values be flushed to zero. Software loads the word through a single-cycle write port, and only the implemented bits are kept.

The completion strobe and the write port are plain one-cycle strobes. The controller takes one of each on every clock and never stalls, so there is no back-pressure at either port and no ready signal.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset `csr_value` is 0, `trap_req` is 0, `trap_code` is 0, `round_trunc` is 0 and `flush_denorm` is 0.
- R2: A write (`wr_en`=1) makes `csr_value` equal `wr_data & 32'h0005_FFFF` on the following cycle. All other bits read as zero.
- R3: Word layout: rounding mode in [1:0], sticky flags in [6:2], enables in [11:7], causes in [16:12] and the denormal-flush bit in [18]. Inside each five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. `op_flags` uses the same bit order.
- R4: On an accepted completion (`op_done`=1, `wr_en`=0) the cause field is replaced by exactly the exception bits of that operation. Causes from earlier operations do not survive.
- R5: On an accepted completion the new causes are ORed into the sticky flags. Completions never clear a flag.
- R6: If an accepted completion's causes AND the stored enables are nonzero, `trap_req` is 1 for exactly the next cycle with `trap_code` = 12'h120. The updated flags remain afterwards.
- R7: If the causes AND the enables are zero, no trap is raised. `trap_code` is 0 whenever `trap_req` is 0.
- R8: `round_trunc` is 1 only when the rounding-mode field holds 2'b01. The encodings 00, 10 and 11 give 0 (round-to-nearest-even).
- R9: `flush_denorm` follows bit 18 of the word.
- R10: For a reciprocal-square-root completion (`op_recip_sqrt`=1), inexact is reported as the cause when the operation raised no other flag. If it raised others, they are used unchanged.
- R11: When a write and a completion occur in the same cycle, the write wins. The completion is discarded and raises no trap.
- R12: With neither a write nor a completion, the word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| op_done | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Raw exception flags of the completed operation |
| op_recip_sqrt | input | 1 | Completed operation was a reciprocal square root approximation |
| csr_value | output | 32 | Current status/control word |
| round_trunc | output | 1 | 1 = truncate, 0 = round to nearest even |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Exception code while `trap_req` is high, else 0 |

## Verification
The bench runs a completion that raises invalid and then one that raises only inexact. A design that accumulated causes instead of rebuilding them would still show invalid in the cause field, while the sticky flags must keep both bits. It enables divide-by-zero only and then runs a divide-by-zero completion and an overflow completion. A design that traps on flags, or on anything other than cause AND enable, fires on the wrong one, and a trap that lasts longer than one cycle is caught on the cycle after the pulse. The bench also issues a write and a trapping completion in the same cycle and covers the reciprocal-square-root case with no flags and with one flag, which exposes a lost write priority and an inexact bit that is forced or dropped in the wrong case.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int N_EXC     = 5;
  localparam int CSR_W     = 32;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + N_EXC;
  localparam int CAUSE_LSB = EN_LSB + N_EXC;
  localparam int DN_BIT    = 18;

  localparam logic [RM_W-1:0]  RM_TRUNC = 2'b01;
  localparam logic [CSR_W-1:0] WR_MASK  = 32'h0005_FFFF;

  // bit order inside every exception field
  localparam int EXC_I = 0;
  localparam int EXC_U = 1;
  localparam int EXC_O = 2;
  localparam int EXC_Z = 3;
  localparam int EXC_V = 4;

  typedef logic [N_EXC-1:0] exc_t;
endpackage

// File: rtl/fpsr_cause_gen.sv
module fpsr_cause_gen
  import fpsr_pkg::*;
(
  input  exc_t raw_flags,
  input  logic recip_sqrt,
  output exc_t cause
);
  // reciprocal sqrt approximation is never exact: report inexact when nothing else fired
  always_comb begin
    cause = raw_flags;
    if (recip_sqrt && (raw_flags == '0)) cause[EXC_I] = 1'b1;
  end
endmodule

// File: rtl/fpsr_state.sv
module fpsr_state
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             op_accept,
  input  exc_t             cause_in,
  output logic [CSR_W-1:0] csr,
  output exc_t             enables,
  output logic [RM_W-1:0]  rmode,
  output logic             dn
);
  logic [RM_W-1:0] rm_q;
  exc_t            flag_q, en_q, cause_q;
  logic            dn_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~WR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_q <= '0;
      en_q <= '0;
      dn_q <= 1'b0;
    end else if (wr_en) begin
      rm_q <= wr_data[RM_LSB +: RM_W];
      en_q <= wr_data[EN_LSB +: N_EXC];
      dn_q <= wr_data[DN_BIT];
    end
  end

  // per-kind cause and sticky flag bits
  for (genvar k = 0; k < N_EXC; k++) begin : g_kind
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause_q[k] <= 1'b0;
        flag_q[k]  <= 1'b0;
      end else if (wr_en) begin
        cause_q[k] <= wr_data[CAUSE_LSB + k];
        flag_q[k]  <= wr_data[FLAG_LSB + k];
      end else if (op_accept) begin
        cause_q[k] <= cause_in[k];
        flag_q[k]  <= flag_q[k] | cause_in[k];
      end
    end
  end

  always_comb begin
    csr                       = '0;
    csr[RM_LSB +: RM_W]       = rm_q;
    csr[FLAG_LSB +: N_EXC]    = flag_q;
    csr[EN_LSB +: N_EXC]      = en_q;
    csr[CAUSE_LSB +: N_EXC]   = cause_q;
    csr[DN_BIT]               = dn_q;
  end

  assign enables = en_q;
  assign rmode   = rm_q;
  assign dn      = dn_q;
endmodule

// File: rtl/fpsr_trap_gen.sv
module fpsr_trap_gen
  import fpsr_pkg::*;
#(
  parameter int                 CODE_W = 12,
  parameter logic [CODE_W-1:0]  CODE   = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_accept,
  input  exc_t              cause,
  input  exc_t              enables,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic trap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= op_accept && ((cause & enables) != '0);
  end

  assign trap_req  = trap_q;
  assign trap_code = trap_q ? CODE : '0;
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter int                TRAP_CODE_W = 12,
  parameter logic [TRAP_CODE_W-1:0] TRAP_CODE = 12'h120
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  input  logic                   op_done,
  input  logic [4:0]             op_flags,
  input  logic                   op_recip_sqrt,
  output logic [31:0]            csr_value,
  output logic                   round_trunc,
  output logic                   flush_denorm,
  output logic                   trap_req,
  output logic [TRAP_CODE_W-1:0] trap_code
);
  exc_t            cause_new, enables;
  logic [RM_W-1:0] rmode;
  logic            dn;
  logic            op_accept;

  // a write in the same cycle discards the completion
  assign op_accept = op_done && !wr_en;

  fpsr_cause_gen u_cause (
    .raw_flags  (op_flags),
    .recip_sqrt (op_recip_sqrt),
    .cause      (cause_new)
  );

  fpsr_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_accept (op_accept),
    .cause_in  (cause_new),
    .csr       (csr_value),
    .enables   (enables),
    .rmode     (rmode),
    .dn        (dn)
  );

  fpsr_trap_gen #(.CODE_W(TRAP_CODE_W), .CODE(TRAP_CODE)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_accept (op_accept),
    .cause     (cause_new),
    .enables   (enables),
    .trap_req  (trap_req),
    .trap_code (trap_code)
  );

  assign round_trunc  = (rmode == RM_TRUNC);
  assign flush_denorm = dn;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk
  import fpsr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        op_done,
  input logic [31:0] csr_value,
  input logic        round_trunc,
  input logic        flush_denorm,
  input logic        trap_req,
  input logic [11:0] trap_code
);
  a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> csr_value == ($past(wr_data) & WR_MASK));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en) |=>
      ((csr_value[FLAG_LSB +: N_EXC] & $past(csr_value[FLAG_LSB +: N_EXC]))
        == $past(csr_value[FLAG_LSB +: N_EXC])));

  a_r6_trap_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(op_done) && !$past(wr_en)));

  a_r6_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_code == 12'h120);

  a_r7_no_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_code == '0);

  a_r8_round_sel: assert property (@(posedge clk) disable iff (!rst_n)
    round_trunc == (csr_value[RM_LSB +: RM_W] == RM_TRUNC));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_denorm == csr_value[DN_BIT]);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !trap_req);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done) |=> $stable(csr_value));
endmodule

bind fpsr_ctrl fpsr_ctrl_chk u_fpsr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .op_done      (op_done),
  .csr_value    (csr_value),
  .round_trunc  (round_trunc),
  .flush_denorm (flush_denorm),
  .trap_req     (trap_req),
  .trap_code    (trap_code)
);

// File: tb/tb_fpsr_ctrl.sv
module tb_fpsr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0005_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        op_recip_sqrt = 1'b0;
  logic [31:0] csr_value;
  logic        round_trunc, flush_denorm, trap_req;
  logic [11:0] trap_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_csr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpsr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_flags(op_flags), .op_recip_sqrt(op_recip_sqrt),
    .csr_value(csr_value), .round_trunc(round_trunc), .flush_denorm(flush_denorm),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    exp_csr = v & MASK;
  endtask

  // returns expected trap bit; model: cause field replaced, flags ORed
  task automatic do_op(input logic [4:0] f, input logic rs, output logic exp_trap);
    logic [4:0] c;
    @(negedge clk); op_done = 1'b1; op_flags = f; op_recip_sqrt = rs;
    @(negedge clk); op_done = 1'b0; op_flags = '0; op_recip_sqrt = 1'b0;
    c = (rs && f == 5'd0) ? 5'b00001 : f;
    exp_trap = |(c & exp_csr[11:7]);
    exp_csr[16:12] = c;
    exp_csr[6:2]   = exp_csr[6:2] | c;
  endtask

  task automatic t_reset;
    chk("R1 csr", csr_value, 32'h0);
    chk("R1 trap", {31'b0, trap_req}, 32'h0);
    chk("R1 code", {20'b0, trap_code}, 32'h0);
    chk("R1 round", {31'b0, round_trunc}, 32'h0);
    chk("R1 flush", {31'b0, flush_denorm}, 32'h0);
  endtask

  task automatic t_write_mask;
    do_write(32'hFFFF_FFFF);
    chk("R2 masked write", csr_value, 32'h0005_FFFF);
    chk("R8 rm=11 nearest", {31'b0, round_trunc}, 32'h0);
    do_write(32'h0002_0000); // bit 17 is not implemented
    chk("R2 unimplemented bit", csr_value, 32'h0);
  endtask

  task automatic t_rounding;
    for (int m = 0; m < 4; m++) begin
      do_write(32'(m));
      chk("R8 round select", {31'b0, round_trunc}, (m == 1) ? 32'h1 : 32'h0);
    end
  endtask

  task automatic t_denorm;
    do_write(32'h0004_0000);
    chk("R9 flush on", {31'b0, flush_denorm}, 32'h1);
    do_write(32'h0);
    chk("R9 flush off", {31'b0, flush_denorm}, 32'h0);
  endtask

  task automatic t_cause_replace;
    logic et;
    do_write(32'h0);
    do_op(5'b10000, 1'b0, et);               // invalid
    chk("R4 cause V", csr_value, exp_csr);
    chk("R3 V positions", csr_value, 32'h0001_0040);
    chk("R7 no trap disabled", {31'b0, trap_req}, 32'h0);
    do_op(5'b00001, 1'b0, et);               // inexact only
    chk("R4 cause replaced", csr_value[16:12], 32'h1);
    chk("R5 flags sticky", csr_value[6:2], 32'h11);
    do_op(5'b00000, 1'b0, et);
    chk("R5 flags after clean op", csr_value, exp_csr);
  endtask

  task automatic t_trap;
    logic et;
    do_write(32'h0000_0400);                 // enable divide-by-zero
    do_op(5'b01000, 1'b0, et);
    chk("R6 trap raised", {31'b0, trap_req}, {31'b0, et});
    chk("R6 trap code", {20'b0, trap_code}, 32'h120);
    chk("R6 word after trap", csr_value, exp_csr);
    @(negedge clk);
    chk("R6 single pulse", {31'b0, trap_req}, 32'h0);
    chk("R6 flags kept", csr_value, exp_csr);
    do_op(5'b00100, 1'b0, et);               // overflow, not enabled
    chk("R7 no trap", {31'b0, trap_req}, 32'h0);
    chk("R7 code zero", {20'b0, trap_code}, 32'h0);
  endtask

  task automatic t_recip_sqrt;
    logic et;
    do_write(32'h0);
    do_op(5'b00000, 1'b1, et);
    chk("R10 inexact forced", csr_value[16:12], 32'h01);
    do_op(5'b01000, 1'b1, et);
    chk("R10 other flag kept", csr_value[16:12], 32'h08);
    chk("R10 word", csr_value, exp_csr);
  endtask

  task automatic t_priority;
    do_write(32'h0000_0F80);                 // all enables
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0001;
    op_done = 1'b1; op_flags = 5'b10000;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0; op_flags = '0;
    exp_csr = 32'h1;
    chk("R11 write wins", csr_value, exp_csr);
    chk("R11 no trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_hold;
    do_write(32'h0004_1234);
    repeat (5) @(negedge clk);
    chk("R12 hold", csr_value, 32'h0004_1234 & MASK);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mask();
    t_rounding();
    t_denorm();
    t_cause_replace();
    t_trap();
    t_recip_sqrt();
    t_priority();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule